// File: doc/BRIEF.md
# Selectable Baud Clock Generator

This block derives the bit-rate clock for a serial transmitter and receiver from a 1.8432 MHz reference. The reference reaches the block as a one-cycle enable, `ref_en`, on the fast system clock. A static 4-bit code picks one of ten standard rates. A 2-bit clock-factor code picks how many output pulses make up one bit time: 1, 16 or 64. The result is a one-cycle enable pulse, `bit_clk_en`, that drives both the transmit and the receive side of the serial engine.

A run-time half-rate bit passes only every second pulse of the selected clock, so the output frequency is halved. The factor code becomes a 2-bit range select. The high bit of the range equals factor bit 1, and the low bit equals factor bit 1 AND factor bit 0. The factor code 00 is not a valid setting, so it falls onto the same range as x1. Rate codes above nine produce no output.

Every divisor is the reference frequency divided by (baud × factor), rounded to the nearest integer. The divisors are worked out when the design is built, so the hardware only selects a constant and counts reference pulses against it.

Top module: `baud_clk_gen`

## Requirements
- R1: Rate codes 0 to 9 select 9600, 4800, 2400, 1800, 1200, 600, 300, 150, 110 and 75 baud. With the half-rate bit clear, successive output pulses lie exactly D reference pulses apart, where D = round(1843200 / (baud × factor)). Examples: 192 for 9600 x1, 262 for 110 x64 and 1047 for 110 x16.
- R2: The factor code maps to a range select. The range high bit is factor[1], and the range low bit is factor[1] & factor[0]. Range 00 means x1, range 10 means x16 and range 11 means x64. Factor 01 therefore gives x1, 10 gives x16 and 11 gives x64. The invalid factor 00 behaves as x1. The range select never holds 01.
- R3: With the half-rate bit set, only every second internal division tick reaches the output, so the spacing is 2×D. The first tick after the bit is set is suppressed, and the second one is passed.
- R4: Rate codes 10 to 15 produce no output pulse and hold the divider at zero.
- R5: The divider advances only on cycles where `ref_en` is high. An output pulse is exactly one cycle wide. It appears in the cycle after the clock edge that sampled the reference pulse which completed the count.
- R6: Synchronous active-high reset keeps the output low, clears the range select to 00, clears the half-rate state and restarts the count. The first pulse after reset comes on the D-th reference pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle enable at the 1.8432 MHz reference rate |
| rate_sel | input | 4 | Static baud rate code (0..9 valid) |
| factor | input | 2 | Clock factor code (01 x1, 10 x16, 11 x64) |
| half_rate | input | 1 | Halves the selected clock when set |
| bit_clk_en | output | 1 | One-cycle bit clock enable for transmit and receive |

## Verification
The assertions assume that `ref_en` arrives as single-cycle pulses, that the rate and factor codes are only changed while reset is held, and that reset is asserted from time zero. The one-cycle output width depends on the smallest divisor being three and on the count restarting after each tick. The bench respects these assumptions. Every scenario loads its settings, pulses reset and then drives reference pulses with one idle cycle between them. The half-rate bit is always set before reset is released.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  localparam int unsigned NUM_RATES = 10;

  // Range select encoding (01 never produced)
  localparam logic [1:0] RNG_X1  = 2'b00;
  localparam logic [1:0] RNG_X16 = 2'b10;
  localparam logic [1:0] RNG_X64 = 2'b11;

  function automatic int unsigned baud_of(input int unsigned code);
    case (code)
      0: return 9600;
      1: return 4800;
      2: return 2400;
      3: return 1800;
      4: return 1200;
      5: return 600;
      6: return 300;
      7: return 150;
      8: return 110;
      9: return 75;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned divisor_of(input int unsigned ref_hz,
                                             input int unsigned baud,
                                             input int unsigned mult);
    if (baud == 0) return 0;
    return (ref_hz + (baud * mult) / 2) / (baud * mult);
  endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baudgen_pkg::*;
#(
  parameter int unsigned REF_HZ = 1843200,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned CNT_W  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic [1:0]       factor,
  input  logic             half_rate,
  output logic [CNT_W-1:0] div_o,
  output logic             valid_o,
  output logic             half_o
);
  localparam int unsigned CODES = 2 ** SEL_W;

  logic [SEL_W-1:0] rate_q;
  logic [1:0]       range_q;
  logic             half_q;

  logic [CNT_W-1:0] tab_x1  [CODES];
  logic [CNT_W-1:0] tab_x16 [CODES];
  logic [CNT_W-1:0] tab_x64 [CODES];

  for (genvar i = 0; i < CODES; i++) begin : g_tab
    assign tab_x1[i]  = CNT_W'(divisor_of(REF_HZ, baud_of(i), 1));
    assign tab_x16[i] = CNT_W'(divisor_of(REF_HZ, baud_of(i), 16));
    assign tab_x64[i] = CNT_W'(divisor_of(REF_HZ, baud_of(i), 64));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= '0;
      range_q <= RNG_X1;
      half_q  <= 1'b0;
    end else begin
      rate_q  <= rate_sel;
      range_q <= {factor[1], factor[1] & factor[0]};
      half_q  <= half_rate;
    end
  end

  always_comb begin
    case (range_q)
      RNG_X64: div_o = tab_x64[rate_q];
      RNG_X16: div_o = tab_x16[rate_q];
      default: div_o = tab_x1[rate_q];
    endcase
  end

  assign valid_o = (32'(rate_q) < NUM_RATES);
  assign half_o  = half_q;

  // R2
  range_code_chk: assert property (@(posedge clk) disable iff (rst)
    range_q != 2'b01);

  // R6
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (range_q == RNG_X1) && !half_q);

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] count_q;
  logic             wrap;

  assign wrap   = (count_q >= div_i - 1'b1);
  assign tick_o = ref_en_i & valid_i & wrap;

  always_ff @(posedge clk) begin
    if (rst || !valid_i) begin
      count_q <= '0;
    end else if (ref_en_i) begin
      count_q <= wrap ? '0 : count_q + 1'b1;
    end
  end

  // R5
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ref_en_i && valid_i) |=> $stable(count_q));

  // R4
  invalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (count_q == '0));

endmodule

// File: rtl/half_rate_gate.sv
module half_rate_gate (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic half_i,
  output logic out_o
);
  logic phase_q;
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst || !half_i) begin
      phase_q <= 1'b0;
    end else if (tick_i) begin
      phase_q <= ~phase_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= tick_i & (~half_i | phase_q);
  end

  assign out_o = out_q;

  // R3
  half_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (half_i && tick_i && !phase_q) |=> !out_q);

  // R5
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    out_q |=> !out_q);

endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen #(
  parameter int unsigned REF_HZ   = 1843200,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned MIN_BAUD = 75
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic [1:0]       factor,
  input  logic             half_rate,
  output logic             bit_clk_en
);
  localparam int unsigned MAX_DIV = REF_HZ / MIN_BAUD;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] div_w;
  logic             valid_w;
  logic             half_w;
  logic             tick_w;

  baud_cfg_reg #(
    .REF_HZ (REF_HZ),
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W)
  ) i_cfg (
    .clk       (clk),
    .rst       (rst),
    .rate_sel  (rate_sel),
    .factor    (factor),
    .half_rate (half_rate),
    .div_o     (div_w),
    .valid_o   (valid_w),
    .half_o    (half_w)
  );

  baud_divider #(
    .CNT_W (CNT_W)
  ) i_div (
    .clk      (clk),
    .rst      (rst),
    .ref_en_i (ref_en),
    .valid_i  (valid_w),
    .div_i    (div_w),
    .tick_o   (tick_w)
  );

  half_rate_gate i_gate (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_w),
    .half_i (half_w),
    .out_o  (bit_clk_en)
  );

  // R5
  ref_origin_chk: assert property (@(posedge clk) disable iff (rst)
    bit_clk_en |-> $past(ref_en));

endmodule

// File: tb/test_baud_clk_gen.sv
module test_baud_clk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_en = 1'b0;
  logic [3:0] rate_sel = 4'd6;
  logic [1:0] factor = 2'b10;
  logic       half_rate = 1'b0;
  logic       bit_clk_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  baud_clk_gen i_baud_clk_gen (
    .clk        (clk),
    .rst        (rst),
    .ref_en     (ref_en),
    .rate_sel   (rate_sel),
    .factor     (factor),
    .half_rate  (half_rate),
    .bit_clk_en (bit_clk_en)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_div(input int code, input logic [1:0] fac, input bit half);
    int baud;
    int mult;
    int d;
    case (code)
      0: baud = 9600;  1: baud = 4800;  2: baud = 2400; 3: baud = 1800;
      4: baud = 1200;  5: baud = 600;   6: baud = 300;  7: baud = 150;
      8: baud = 110;   9: baud = 75;    default: baud = 0;
    endcase
    mult = (fac == 2'b11) ? 64 : (fac == 2'b10) ? 16 : 1;
    if (baud == 0) return 0;
    d = (1843200 + (baud * mult) / 2) / (baud * mult);
    return half ? 2 * d : d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int code, input logic [1:0] fac, input bit half);
    @(negedge clk);
    rst = 1'b1;
    ref_en = 1'b0;
    rate_sel = code[3:0];
    factor = fac;
    half_rate = half;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // One reference pulse; returns the output seen after it and checks the width.
  task automatic ref_pulse(output bit seen, output bit wide);
    ref_en = 1'b1;
    @(negedge clk);
    seen = bit_clk_en;
    ref_en = 1'b0;
    @(negedge clk);
    wide = bit_clk_en;
  endtask

  // Count reference pulses up to the next output pulse (0 when none within limit).
  task automatic next_out(input int limit, input string req, output int n);
    bit s;
    bit w;
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      ref_pulse(s, w);
      if (w) chk(1'b0, {req, " width"}, 2, 1);
      if (s) begin
        n = k;
        return;
      end
    end
  endtask

  task automatic t_period(input string req, input int code, input logic [1:0] fac,
                          input bit half, input int periods);
    int e;
    int n;
    e = exp_div(code, fac, half);
    do_reset(code, fac, half);
    for (int p = 0; p < periods; p++) begin
      next_out(e + 2, req, n);
      chk(n == e, req, n, e);
    end
  endtask

  task automatic t_reset_state;
    bit s;
    bit w;
    int n;
    int bad;
    bad = 0;
    @(negedge clk);
    rst = 1'b1;
    rate_sel = 4'd0;
    factor = 2'b11;
    half_rate = 1'b0;
    for (int k = 0; k < 10; k++) begin
      ref_pulse(s, w);
      if (s || w) bad++;
    end
    chk(bad == 0, "R6 output low in reset", bad, 0);
    do_reset(0, 2'b01, 1'b0);
    for (int k = 0; k < 100; k++) ref_pulse(s, w);
    do_reset(0, 2'b01, 1'b0);
    next_out(300, "R6 restart", n);
    chk(n == 192, "R6 count restarts after reset", n, 192);
  endtask

  task automatic t_invalid(input int code);
    bit s;
    bit w;
    int outs;
    outs = 0;
    do_reset(code, 2'b11, 1'b0);
    for (int k = 0; k < 300; k++) begin
      ref_pulse(s, w);
      if (s || w) outs++;
    end
    chk(outs == 0, "R4 invalid code silent", outs, 0);
  endtask

  task automatic t_ref_hold;
    bit s;
    bit w;
    int outs;
    outs = 0;
    do_reset(0, 2'b11, 1'b0);
    ref_pulse(s, w);
    ref_pulse(s, w);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (bit_clk_en) outs++;
    end
    chk(outs == 0, "R5 no output without ref_en", outs, 0);
    ref_pulse(s, w);
    chk(s == 1'b1, "R5 count held across idle", int'(s), 1);
    chk(w == 1'b0, "R5 pulse one cycle wide", int'(w), 0);
  endtask

  initial begin
    t_reset_state();
    t_period("R1 R2 300 baud x16", 6, 2'b10, 1'b0, 2);
    t_period("R1 R2 9600 x64", 0, 2'b11, 1'b0, 4);
    t_period("R1 110 x64 rounding", 8, 2'b11, 1'b0, 2);
    t_period("R1 110 x16 rounding", 8, 2'b10, 1'b0, 1);
    t_period("R1 R2 9600 x1 factor 01", 0, 2'b01, 1'b0, 2);
    t_period("R2 factor 00 acts as x1", 0, 2'b00, 1'b0, 2);
    t_period("R1 1800 x1", 3, 2'b01, 1'b0, 1);
    t_period("R1 75 x1", 9, 2'b01, 1'b0, 1);
    t_period("R3 half rate 9600 x64", 0, 2'b11, 1'b1, 3);
    t_period("R3 half rate 1200 x16", 4, 2'b10, 1'b1, 2);
    t_invalid(10);
    t_invalid(15);
    t_ref_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule